// File: doc/BRIEF.md
# GPIO Event Detect Interrupt Unit

This block watches a set of general-purpose pins and records events on them. Each pin can be armed independently for six kinds of event: a rising edge, a falling edge, a high level or a low level seen through the synchronized sample path, and a rising or falling edge taken on an early-tap path that reacts one cycle sooner. Any armed event sets the pin's bit in a sticky status register. Software clears that bit by writing a one to it.

The status bits are ORed into three interrupt request lines, and each line covers a fixed span of pins. Pins 0 to 27 drive line 0, pins 28 to 45 drive line 1 and pins 46 to 53 drive line 2, so the middle line takes pins from both 32-bit register lanes. Software reaches the block through a plain 32-bit register port with byte addresses. Every register is split into two lanes at consecutive word addresses. Lane 0 holds pins 0 to 31 and lane 1 holds pins 32 to 53.

Top module: `gpio_event_unit`

## Requirements
- R1: After reset, every arm register and both status lanes read 0, and all three interrupt lines are low.
- R2: The arm registers for the six kinds can be written and read back. They sit at byte address 0x4C + 12*k + 4*lane, with k = 0 rising, 1 falling, 2 high level, 3 low level, 4 early rising, 5 early falling. Writing one register leaves the other registers unchanged.
- R3: A synchronized rising or falling edge sets the pin's status bit (0x40 for lane 0, 0x44 for lane 1). The bit is readable after the fourth clock edge that follows the pin change, and not after the third.
- R4: When both rising and falling are armed for a pin, each of the two edges sets the status bit.
- R5: An armed high or low level sets the status bit on every cycle in which the level is present. A clear written while the level holds leaves the bit at 1. Once the level is gone the bit stays at 1 until it is cleared.
- R6: An early-path edge sets the status bit after the third clock edge that follows the pin change, which is one cycle before a synchronized edge would.
- R7: Writing a status lane clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: If a clear write and a new event hit the same status bit in the same cycle, the bit ends at 1.
- R9: Clearing an arm bit does not clear a status bit that is already set, and that bit keeps driving its interrupt line.
- R10: Interrupt line 0 is high exactly when any status bit for pins 0 to 27 is set. Line 1 does the same for pins 28 to 45, and line 2 for pins 46 to 53.
- R11: Lane 1 bits 22 to 31 always read 0, and writes to them are ignored. Addresses that are not mapped read 0.
- R12: A pin change whose kind is not armed leaves the status bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_i | input | 54 | Asynchronous pin levels |
| irq_o | output | 3 | Interrupt requests, one per pin group |

## Verification
The hardest case to reach is a clear write that lands on the exact cycle in which a new event is latched for the same bit. The stimulus arms an early-path rising edge, because that path has a short and fixed latency. It raises the pin on one falling clock edge and asserts the clear write two cycles later, so the write commits on the same edge as the event. A second hard case is a clear written while an armed level is still present. The stimulus holds the pin high, issues the clear, and reads the bit back on the very next cycle.

// File: rtl/gpev_pkg.sv
package gpev_pkg;

    localparam int REG_W       = 32;
    localparam int ADDR_W      = 8;
    localparam int N_KINDS     = 6;
    localparam int KIND_STRIDE = 12;
    localparam int LANE_STRIDE = 4;

    localparam logic [ADDR_W-1:0] STATUS_BASE = 8'h40;
    localparam logic [ADDR_W-1:0] ARM_BASE    = 8'h4C;

    typedef enum logic [2:0] {
        DK_RISE  = 3'd0,
        DK_FALL  = 3'd1,
        DK_HIGH  = 3'd2,
        DK_LOW   = 3'd3,
        DK_ERISE = 3'd4,
        DK_EFALL = 3'd5
    } detect_kind_e;

    typedef struct packed {
        logic         hit;
        logic         is_status;
        detect_kind_e kind;
        logic [1:0]   lane;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a, input int n_lanes);
        reg_sel_t s;
        s      = '0;
        s.kind = DK_RISE;
        for (int b = 0; b < n_lanes; b++) begin
            if (a == STATUS_BASE + ADDR_W'(LANE_STRIDE * b)) begin
                s.hit       = 1'b1;
                s.is_status = 1'b1;
                s.lane      = 2'(b);
            end
            for (int k = 0; k < N_KINDS; k++) begin
                if (a == ARM_BASE + ADDR_W'(KIND_STRIDE * k + LANE_STRIDE * b)) begin
                    s.hit       = 1'b1;
                    s.is_status = 1'b0;
                    s.kind      = detect_kind_e'(3'(k));
                    s.lane      = 2'(b);
                end
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/gpev_sync.sv
module gpev_sync #(
    parameter int WIDTH  = 54,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] early_o,
    output logic [WIDTH-1:0] late_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign early_o = chain_q[STAGES-2];
    assign late_o  = chain_q[STAGES-1];
endmodule

// File: rtl/gpev_detect.sv
module gpev_detect
    import gpev_pkg::*;
#(
    parameter int WIDTH = 54
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [WIDTH-1:0]                early_i,
    input  logic [WIDTH-1:0]                late_i,
    input  logic [N_KINDS-1:0][WIDTH-1:0]   arm_i,
    output logic [WIDTH-1:0]                evt_o
);
    logic [WIDTH-1:0]              prev_q;
    logic [N_KINDS-1:0][WIDTH-1:0] cond;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= late_i;
    end

    always_comb begin
        cond                  = '0;
        cond[int'(DK_RISE)]   = late_i & ~prev_q;
        cond[int'(DK_FALL)]   = ~late_i & prev_q;
        cond[int'(DK_HIGH)]   = late_i;
        cond[int'(DK_LOW)]    = ~late_i;
        cond[int'(DK_ERISE)]  = early_i & ~late_i;
        cond[int'(DK_EFALL)]  = ~early_i & late_i;
    end

    always_comb begin
        evt_o = '0;
        for (int k = 0; k < N_KINDS; k++) evt_o = evt_o | (cond[k] & arm_i[k]);
    end

    AST_EARLY_LEADS_SYNC: assert property (@(posedge clk) disable iff (rst)
        (cond[int'(DK_RISE)] & ~$past(cond[int'(DK_ERISE)])) == '0); // R6
endmodule

// File: rtl/gpev_regs.sv
module gpev_regs
    import gpev_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we_i,
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [REG_W-1:0]                   wdata_i,
    input  logic [NUM_PINS-1:0]                evt_i,
    output logic [REG_W-1:0]                   rdata_o,
    output logic [N_KINDS-1:0][NUM_PINS-1:0]   arm_o,
    output logic [NUM_PINS-1:0]                status_o
);
    localparam int N_LANES  = (NUM_PINS + REG_W - 1) / REG_W;
    localparam int TOP_BITS = NUM_PINS - (N_LANES - 1) * REG_W;
    localparam logic [REG_W-1:0] TOP_MASK = REG_W'((64'd1 << TOP_BITS) - 64'd1);

    reg_sel_t                    sel;
    logic [NUM_PINS-1:0]         wr_pins;
    logic [NUM_PINS-1:0]         lane_pins;
    logic [NUM_PINS-1:0]         clr_mask;
    logic [NUM_PINS-1:0]         src;
    logic [N_KINDS-1:0][NUM_PINS-1:0] arm_q;
    logic [NUM_PINS-1:0]         status_q;

    assign sel = decode_addr(addr_i, N_LANES);

    always_comb begin
        wr_pins   = '0;
        lane_pins = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (sel.lane == 2'(i / REG_W)) begin
                wr_pins[i]   = wdata_i[i % REG_W];
                lane_pins[i] = 1'b1;
            end
        end
    end

    assign clr_mask = (we_i && sel.hit && sel.is_status) ? wr_pins : '0;

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_mask) | evt_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= '0;
        end else if (we_i && sel.hit && !sel.is_status) begin
            for (int k = 0; k < N_KINDS; k++)
                if (sel.kind == detect_kind_e'(3'(k)))
                    arm_q[k] <= (arm_q[k] & ~lane_pins) | wr_pins;
        end
    end

    always_comb begin
        src = status_q;
        if (!sel.is_status) begin
            for (int k = 0; k < N_KINDS; k++)
                if (sel.kind == detect_kind_e'(3'(k))) src = arm_q[k];
        end
        rdata_o = '0;
        if (sel.hit) begin
            for (int i = 0; i < NUM_PINS; i++)
                if (sel.lane == 2'(i / REG_W)) rdata_o[i % REG_W] = src[i];
        end
    end

    assign arm_o    = arm_q;
    assign status_o = status_q;

    AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~$past(status_q)) & ~$past(evt_i)) == '0); // R12
    AST_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (($past(status_q) & ~status_q) & ~$past(clr_mask)) == '0); // R9
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(evt_i) & ~status_q) == '0); // R8
    AST_TOP_LANE_PADDED: assert property (@(posedge clk) disable iff (rst)
        (sel.hit && sel.lane == 2'(N_LANES - 1)) |-> ((rdata_o & ~TOP_MASK) == '0)); // R11
endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit
    import gpev_pkg::*;
#(
    parameter int NUM_PINS    = 54,
    parameter int GROUP0_LAST = 27,
    parameter int GROUP1_LAST = 45,
    parameter int SYNC_STAGES = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [7:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [2:0]          irq_o
);
    logic [NUM_PINS-1:0]              early;
    logic [NUM_PINS-1:0]              late;
    logic [NUM_PINS-1:0]              evt;
    logic [NUM_PINS-1:0]              status;
    logic [N_KINDS-1:0][NUM_PINS-1:0] arm;

    gpev_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i(pin_i), .early_o(early), .late_o(late)
    );

    gpev_detect #(.WIDTH(NUM_PINS)) u_detect (
        .clk(clk), .rst(rst), .early_i(early), .late_i(late), .arm_i(arm), .evt_o(evt)
    );

    gpev_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst(rst), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
        .evt_i(evt), .rdata_o(reg_rdata), .arm_o(arm), .status_o(status)
    );

    assign irq_o[0] = |status[GROUP0_LAST:0];
    assign irq_o[1] = |status[GROUP1_LAST:GROUP0_LAST+1];
    assign irq_o[2] = |status[NUM_PINS-1:GROUP1_LAST+1];

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |-> (irq_o == 3'b000)); // R10
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_o == 3'b000 && status == '0)); // R1
endmodule

// File: tb/sim_gpio_event_unit.sv
module sim_gpio_event_unit;
    localparam int NP = 54;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = 8'h00;
    logic [31:0]   reg_wdata = 32'h0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pin_i = '0;
    logic [2:0]    irq_o;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;

    always #4 clk = ~clk;

    gpio_event_unit u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_i(pin_i), .irq_o(irq_o)
    );

    function automatic logic [7:0] stat_a(input int lane);
        return 8'h40 + 8'(4 * lane);
    endfunction

    function automatic logic [7:0] arm_a(input int kind, input int lane);
        return 8'h4C + 8'(12 * kind + 4 * lane);
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it  = exp_q.pop_front();
                act = it.is_irq ? {29'b0, irq_o} : reg_rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic chk_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        exp_q.push_back('{is_irq: 1'b0, exp: e, tag: tag});
    endtask

    task automatic chk_irq(input logic [2:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back('{is_irq: 1'b1, exp: {29'b0, e}, tag: tag});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setpin(input int p, input logic v);
        @(negedge clk);
        pin_i[p] = v;
    endtask

    task automatic level_irq(input int p, input logic [2:0] e);
        wr(arm_a(2, p / 32), 32'd1 << (p % 32));
        setpin(p, 1'b1);
        idle(5);
        chk_irq(e, "R10 group line high");
        setpin(p, 1'b0);
        idle(5);
        wr(stat_a(p / 32), 32'd1 << (p % 32));
        chk_irq(3'b000, "R10 group line low after clear");
        wr(arm_a(2, p / 32), 32'h0);
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (R1..R12 run): got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk_reg(stat_a(0), 32'h0, "R1 status lane0");
        chk_reg(stat_a(1), 32'h0, "R1 status lane1");
        chk_reg(arm_a(0, 0), 32'h0, "R1 rise arm");
        chk_reg(arm_a(5, 1), 32'h0, "R1 efall arm lane1");
        chk_irq(3'b000, "R1 irq");

        // R2 arm registers / R11 padding and unmapped
        wr(arm_a(0, 0), 32'hA5A5A5A5);
        chk_reg(arm_a(0, 0), 32'hA5A5A5A5, "R2 rise readback");
        wr(arm_a(1, 0), 32'h5A5A5A5A);
        chk_reg(arm_a(1, 0), 32'h5A5A5A5A, "R2 fall readback");
        chk_reg(arm_a(0, 0), 32'hA5A5A5A5, "R2 neighbour untouched");
        wr(arm_a(5, 1), 32'hFFFFFFFF);
        chk_reg(arm_a(5, 1), 32'h003FFFFF, "R11 lane1 upper bits");
        chk_reg(8'h00, 32'h0, "R11 unmapped 0x00");
        chk_reg(8'h48, 32'h0, "R11 unmapped 0x48");
        wr(arm_a(0, 0), 32'h0);
        wr(arm_a(1, 0), 32'h0);
        wr(arm_a(5, 1), 32'h0);

        // R3 sync rising edge latency on pin 3, R12 unarmed fall
        wr(arm_a(0, 0), 32'h8);
        setpin(3, 1'b1);
        chk_reg(stat_a(0), 32'h0, "R3 not after edge 1");
        chk_reg(stat_a(0), 32'h0, "R3 not after edge 2");
        chk_reg(stat_a(0), 32'h0, "R3 not after edge 3");
        chk_reg(stat_a(0), 32'h8, "R3 set after edge 4");
        chk_irq(3'b001, "R10 pin3 line0");
        wr(stat_a(0), 32'h8);
        chk_reg(stat_a(0), 32'h0, "R7 clear pin3");
        setpin(3, 1'b0);
        idle(5);
        chk_reg(stat_a(0), 32'h0, "R12 unarmed fall ignored");

        // R4 both edges on pin 40 (lane1 bit 8)
        wr(arm_a(0, 1), 32'h100);
        wr(arm_a(1, 1), 32'h100);
        setpin(40, 1'b1);
        idle(5);
        chk_reg(stat_a(1), 32'h100, "R4 rising with both armed");
        chk_irq(3'b010, "R10 pin40 line1");
        wr(stat_a(1), 32'h100);
        chk_reg(stat_a(1), 32'h0, "R7 clear pin40");
        setpin(40, 1'b0);
        idle(5);
        chk_reg(stat_a(1), 32'h100, "R4 falling with both armed");
        wr(stat_a(1), 32'h100);
        wr(arm_a(0, 1), 32'h0);
        wr(arm_a(1, 1), 32'h0);

        // R7 partial clear on pins 0 and 1
        wr(arm_a(0, 0), 32'h3);
        @(negedge clk);
        pin_i[0] = 1'b1; pin_i[1] = 1'b1;
        idle(5);
        chk_reg(stat_a(0), 32'h3, "R7 both set");
        wr(stat_a(0), 32'h2);
        chk_reg(stat_a(0), 32'h1, "R7 zero bit kept");
        wr(stat_a(0), 32'h1);
        chk_reg(stat_a(0), 32'h0, "R7 all cleared");

        // R9 disarm keeps status
        wr(arm_a(0, 0), 32'h1);
        @(negedge clk);
        pin_i[0] = 1'b0; pin_i[1] = 1'b0;
        idle(5);
        chk_reg(stat_a(0), 32'h0, "R12 fall unarmed");
        setpin(0, 1'b1);
        idle(5);
        wr(arm_a(0, 0), 32'h0);
        chk_reg(stat_a(0), 32'h1, "R9 status kept after disarm");
        chk_irq(3'b001, "R9 irq kept after disarm");
        wr(stat_a(0), 32'h1);
        chk_reg(stat_a(0), 32'h0, "R9 cleared");
        setpin(0, 1'b0);

        // R5 level high on pin 10
        wr(arm_a(2, 0), 32'h400);
        setpin(10, 1'b1);
        idle(6);
        chk_reg(stat_a(0), 32'h400, "R5 high level sets");
        wr(stat_a(0), 32'h400);
        chk_reg(stat_a(0), 32'h400, "R5 clear ignored while high");
        setpin(10, 1'b0);
        idle(5);
        chk_reg(stat_a(0), 32'h400, "R5 stays after level gone");
        wr(stat_a(0), 32'h400);
        chk_reg(stat_a(0), 32'h0, "R5 clear after level gone");
        wr(arm_a(2, 0), 32'h0);

        // R5 level low on pin 53 (lane1 bit 21)
        wr(arm_a(3, 1), 32'h200000);
        idle(4);
        chk_reg(stat_a(1), 32'h200000, "R5 low level sets");
        chk_irq(3'b100, "R10 pin53 line2");
        setpin(53, 1'b1);
        idle(5);
        wr(stat_a(1), 32'h200000);
        chk_reg(stat_a(1), 32'h0, "R5 low cleared after rise");
        wr(arm_a(3, 1), 32'h0);
        setpin(53, 1'b0);
        idle(4);

        // R6 early rise on pin 20 vs sync rise on pin 21
        wr(arm_a(4, 0), 32'h100000);
        wr(arm_a(0, 0), 32'h200000);
        @(negedge clk);
        pin_i[20] = 1'b1; pin_i[21] = 1'b1;
        chk_reg(stat_a(0), 32'h0, "R6 none after edge 1");
        chk_reg(stat_a(0), 32'h0, "R6 none after edge 2");
        chk_reg(stat_a(0), 32'h100000, "R6 early only after edge 3");
        chk_reg(stat_a(0), 32'h300000, "R3 sync after edge 4");
        wr(stat_a(0), 32'h300000);
        wr(arm_a(4, 0), 32'h0);
        wr(arm_a(0, 0), 32'h0);
        wr(arm_a(5, 0), 32'h100000);
        setpin(20, 1'b0);
        chk_reg(stat_a(0), 32'h0, "R6 efall none after edge 1");
        chk_reg(stat_a(0), 32'h0, "R6 efall none after edge 2");
        chk_reg(stat_a(0), 32'h100000, "R6 efall after edge 3");
        wr(stat_a(0), 32'h100000);
        wr(arm_a(5, 0), 32'h0);
        pin_i[21] = 1'b0;
        idle(5);

        // R8 clear and event on the same edge, pin 25
        wr(arm_a(4, 0), 32'h2000000);
        setpin(25, 1'b1);
        idle(1);
        wr(stat_a(0), 32'h2000000);
        chk_reg(stat_a(0), 32'h2000000, "R8 event wins over clear");
        wr(stat_a(0), 32'h2000000);
        chk_reg(stat_a(0), 32'h0, "R8 later clear works");
        wr(arm_a(4, 0), 32'h0);
        setpin(25, 1'b0);
        idle(4);

        // R10 group boundaries
        level_irq(27, 3'b001);
        level_irq(28, 3'b010);
        level_irq(45, 3'b010);
        level_irq(46, 3'b100);

        idle(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule